// File: doc/BRIEF.md
# Parallel NOR Flash Geometry Probe

This block is a sequencer that finds out the shape of one parallel NOR flash device on a simple byte-wide memory-mapped bus. After a `start` pulse it resets the device, puts it into query mode and checks for the three-letter query signature. It then reads the command-set identifier, the timeout exponents, the size exponent and the erase-region descriptors. The descriptors are turned into a table of regions while they arrive: each entry holds a start offset, a block count and a block size in bytes.

When the table is complete, the engine takes the device out of query mode. The exit command depends on the command set. The engine then raises a one-cycle `done` pulse and a `devValid` flag that stays set. The write and erase timeouts are reported in clock cycles. Software or other hardware then reads the region table through an indexed port. The bus is command-addressed. In 16-bit mode every command offset, for both writes and reads, is doubled before it reaches the byte address. Read data returns exactly one cycle after `busRdEn`.

Top module: `cfi_probe_top`

## Requirements
- R1: After an accepted `start`, the first two bus writes are data 0xF0 at command offset 0x00, then data 0x98 at command offset 0x55.
- R2: The byte address equals the command offset shifted left by one when `is16Bit` is 1, and equals the command offset otherwise. This holds for writes and reads alike. Each read request lasts a single cycle.
- R3: The bytes at query offsets 0x10, 0x11 and 0x12 must be 0x51, 0x52 and 0x59. On the first mismatch the engine issues no further bus access and pulses `done` with `devValid` = 0.
- R4: `cmdSet` is the little-endian word formed from offset 0x13 (low byte) and offset 0x14 (high byte).
- R5: `wrTimeoutCyc` = CLK_PER_US × 2^(byte 0x1F + byte 0x23) and `erTimeoutCyc` = CLK_PER_MS × 2^(byte 0x21 + byte 0x25). Each result saturates to all ones when it does not fit in CNT_W bits.
- R6: `devSize` = 2^(byte 0x27). It saturates to all ones when the exponent is OFFS_W or more.
- R7: `numRegions` = min(byte 0x2C, MAX_RGN). Only that many descriptors are read. The read port returns zeros for any `rgnSel` ≥ `numRegions`.
- R8: For region r, the little-endian word at 0x2D+4r gives the block count minus one. The word at 0x2D+4r+2 gives the block size divided by 256, and a word of 0 means 128 bytes.
- R9: Region 0 starts at offset 0. Each later region starts at the previous start plus the previous count × size, modulo 2^OFFS_W.
- R10: To leave query mode, command set 2 gets 0xF0 then 0xFF at command offset 0. Command sets 1 and 3 get 0xFF only. Any other command set gets no exit write.
- R11: After reset `done`, `devValid` and both bus strobes are 0. `done` is a single-cycle pulse during which the bus is idle. `start` is ignored while a probe is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a probe (ignored while busy) |
| is16Bit | input | 1 | Device answers commands on even byte addresses |
| busAddr | output | ADDR_W | Byte address |
| busWrEn | output | 1 | Write strobe |
| busWrData | output | 8 | Write data |
| busRdEn | output | 1 | Read request |
| busRdData | input | 8 | Read data, valid one cycle after the request |
| done | output | 1 | Probe finished (one cycle) |
| devValid | output | 1 | Signature matched; held until next start |
| cmdSet | output | 16 | Command-set identifier |
| devSize | output | OFFS_W | Device size in bytes |
| numRegions | output | 8 | Stored region count |
| wrTimeoutCyc | output | CNT_W | Write timeout in cycles |
| erTimeoutCyc | output | CNT_W | Erase timeout in cycles |
| rgnSel | input | 8 | Region table index |
| rgnStart | output | OFFS_W | Start offset of selected region |
| rgnBlocks | output | 17 | Block count of selected region |
| rgnBlkSize | output | 24 | Block size in bytes of selected region |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- **Size code of zero.** A design that multiplies the code by 256 without the special case would report zero-byte blocks, and every later start offset would be wrong.
- **Maximum block count of 0xFFFF.** Here the count must widen to 65536; a design that drops the carry would store zero.
- **Region count above the table depth.** A design that does not clip would read past its storage, or report ten regions when it holds eight.
- **Exponents whose sum overflows the counters.** A design without saturation would return small wrapped numbers.
- **Three exit cases and a corrupted signature.** Wrong exit writes, or bus traffic after a failed signature, show up as a write-sequence mismatch.
- **A second `start` in the middle of a run.** A design that restarted would emit a repeated reset write and a second `done`.

// File: rtl/cfi_probe_pkg.sv
package cfi_probe_pkg;

  // number of fixed (non-region) query reads, in issue order
  localparam int FIX_STEPS = 11;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WR_RST,
    S_WR_QRY,
    S_RD_REQ,
    S_RD_CAP,
    S_RGN_CHK,
    S_EXIT_A,
    S_EXIT_B,
    S_DONE
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       clear;    // wipe results for a new probe
    logic       capEn;    // read data is on the bus this cycle
    logic       isRgn;    // byte belongs to a region descriptor
    logic [3:0] fixStep;  // which fixed field (when !isRgn)
    logic [7:0] rgn;      // region index (when isRgn)
    logic [1:0] byteK;    // byte within descriptor (when isRgn)
  } dpStrobe_t;

  // query offset for each fixed step
  function automatic logic [7:0] fixOffset(input logic [3:0] s);
    case (s)
      4'd0:    fixOffset = 8'h10;
      4'd1:    fixOffset = 8'h11;
      4'd2:    fixOffset = 8'h12;
      4'd3:    fixOffset = 8'h13;
      4'd4:    fixOffset = 8'h14;
      4'd5:    fixOffset = 8'h1F;
      4'd6:    fixOffset = 8'h23;
      4'd7:    fixOffset = 8'h21;
      4'd8:    fixOffset = 8'h25;
      4'd9:    fixOffset = 8'h27;
      default: fixOffset = 8'h2C;
    endcase
  endfunction

  // signature byte expected at steps 0..2
  function automatic logic [7:0] sigChar(input logic [3:0] s);
    case (s)
      4'd0:    sigChar = 8'h51;
      4'd1:    sigChar = 8'h52;
      default: sigChar = 8'h59;
    endcase
  endfunction

endpackage

// File: rtl/cfi_probe_ctrl.sv
module cfi_probe_ctrl
  import cfi_probe_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              is16Bit,
  input  logic              sigMiss,
  input  logic [15:0]       cmdSet,
  input  logic [7:0]        rgnCount,
  output dpStrobe_t         stb,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrEn,
  output logic [7:0]        busWrData,
  output logic              busRdEn,
  output logic              done,
  output logic              devValid
);

  localparam int OFF_W = 12;
  localparam logic [3:0] LAST_FIX = 4'(FIX_STEPS - 1);

  ctlState_t        state;
  logic [3:0]       step;
  logic [7:0]       rgnI;
  logic [1:0]       byteK;
  logic             inRgn;
  logic             mode16;
  logic             validQ;
  logic [OFF_W-1:0] cmdOff;
  logic [7:0]       wrByte;

  always_comb begin
    stb     = '0;
    busWrEn = 1'b0;
    busRdEn = 1'b0;
    cmdOff  = '0;
    wrByte  = '0;
    done    = 1'b0;
    case (state)
      S_IDLE:   stb.clear = start;
      S_WR_RST: begin busWrEn = 1'b1; wrByte = 8'hF0; end
      S_WR_QRY: begin busWrEn = 1'b1; cmdOff = 12'h055; wrByte = 8'h98; end
      S_RD_REQ: begin
        busRdEn = 1'b1;
        if (inRgn) cmdOff = 12'h02D + {2'b00, rgnI, 2'b00} + {10'd0, byteK};
        else       cmdOff = {4'h0, fixOffset(step)};
      end
      S_RD_CAP: begin
        stb.capEn   = 1'b1;
        stb.isRgn   = inRgn;
        stb.fixStep = step;
        stb.rgn     = rgnI;
        stb.byteK   = byteK;
      end
      S_EXIT_A: begin busWrEn = 1'b1; wrByte = 8'hF0; end
      S_EXIT_B: begin busWrEn = 1'b1; wrByte = 8'hFF; end
      S_DONE:   done = 1'b1;
      default:  ;
    endcase
  end

  assign busAddr   = ADDR_W'(cmdOff) << mode16;
  assign busWrData = wrByte;
  assign devValid  = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      step   <= '0;
      rgnI   <= '0;
      byteK  <= '0;
      inRgn  <= 1'b0;
      mode16 <= 1'b0;
      validQ <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          mode16 <= is16Bit;
          validQ <= 1'b0;
          step   <= '0;
          rgnI   <= '0;
          byteK  <= '0;
          inRgn  <= 1'b0;
          state  <= S_WR_RST;
        end
        S_WR_RST: state <= S_WR_QRY;
        S_WR_QRY: state <= S_RD_REQ;
        S_RD_REQ: state <= S_RD_CAP;
        S_RD_CAP: begin
          if (!inRgn) begin
            if (sigMiss) begin
              validQ <= 1'b0;
              state  <= S_DONE;
            end else if (step == LAST_FIX) begin
              inRgn <= 1'b1;
              rgnI  <= '0;
              byteK <= '0;
              state <= S_RGN_CHK;
            end else begin
              step  <= step + 4'd1;
              state <= S_RD_REQ;
            end
          end else if (byteK == 2'd3) begin
            byteK <= '0;
            rgnI  <= rgnI + 8'd1;
            state <= S_RGN_CHK;
          end else begin
            byteK <= byteK + 2'd1;
            state <= S_RD_REQ;
          end
        end
        S_RGN_CHK: begin
          if (rgnI < rgnCount) state <= S_RD_REQ;
          else if (cmdSet == 16'd2) state <= S_EXIT_A;
          else if (cmdSet == 16'd1 || cmdSet == 16'd3) state <= S_EXIT_B;
          else begin
            validQ <= 1'b1;
            state  <= S_DONE;
          end
        end
        S_EXIT_A: state <= S_EXIT_B;
        S_EXIT_B: begin
          validQ <= 1'b1;
          state  <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfi_probe_dp.sv
module cfi_probe_dp
  import cfi_probe_pkg::*;
#(
  parameter int MAX_RGN    = 8,
  parameter int CNT_W      = 40,
  parameter int OFFS_W     = 32,
  parameter int CLK_PER_US = 100,
  parameter int CLK_PER_MS = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [7:0]        rdData,
  output logic              sigMiss,
  output logic [15:0]       cmdSet,
  output logic [7:0]        rgnCount,
  output logic [CNT_W-1:0]  wrTimeout,
  output logic [CNT_W-1:0]  erTimeout,
  output logic [OFFS_W-1:0] devSize,
  input  logic [7:0]        rgnSel,
  output logic [OFFS_W-1:0] rgnStart,
  output logic [16:0]       rgnBlocks,
  output logic [23:0]       rgnBlkSize
);

  localparam int BLK_W  = 17;
  localparam int BSZ_W  = 24;
  localparam int SPAN_W = BLK_W + BSZ_W;
  localparam int RI_W   = (MAX_RGN > 1) ? $clog2(MAX_RGN) : 1;

  logic [7:0] bTypW, bMaxW, bTypE, bMaxE, sizeExp;
  logic [7:0] tmp0, tmp1, tmp2;
  logic [OFFS_W-1:0] runOff;

  logic [OFFS_W-1:0] startTab [MAX_RGN];
  logic [BLK_W-1:0]  blkTab   [MAX_RGN];
  logic [BSZ_W-1:0]  sizeTab  [MAX_RGN];

  // region descriptor decode, valid on the fourth byte
  logic [BLK_W-1:0]  blkCnt;
  logic [15:0]       szWord;
  logic [BSZ_W-1:0]  blkSize;
  logic [SPAN_W-1:0] span;
  logic              commit;

  assign blkCnt  = {1'b0, tmp1, tmp0} + 17'd1;
  assign szWord  = {rdData, tmp2};
  assign blkSize = (szWord == 16'd0) ? 24'd128 : {szWord, 8'h00};
  assign span    = {{BSZ_W{1'b0}}, blkCnt} * {{BLK_W{1'b0}}, blkSize};
  assign commit  = stb.capEn && stb.isRgn && (stb.byteK == 2'd3);

  assign sigMiss = stb.capEn && !stb.isRgn && (stb.fixStep < 4'd3) &&
                   (rdData != sigChar(stb.fixStep));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdSet   <= '0;
      rgnCount <= '0;
      bTypW    <= '0;
      bMaxW    <= '0;
      bTypE    <= '0;
      bMaxE    <= '0;
      sizeExp  <= '0;
      tmp0     <= '0;
      tmp1     <= '0;
      tmp2     <= '0;
      runOff   <= '0;
      for (int i = 0; i < MAX_RGN; i++) begin
        startTab[i] <= '0;
        blkTab[i]   <= '0;
        sizeTab[i]  <= '0;
      end
    end else if (stb.clear) begin
      cmdSet   <= '0;
      rgnCount <= '0;
      bTypW    <= '0;
      bMaxW    <= '0;
      bTypE    <= '0;
      bMaxE    <= '0;
      sizeExp  <= '0;
      runOff   <= '0;
      for (int i = 0; i < MAX_RGN; i++) begin
        startTab[i] <= '0;
        blkTab[i]   <= '0;
        sizeTab[i]  <= '0;
      end
    end else if (stb.capEn) begin
      if (!stb.isRgn) begin
        case (stb.fixStep)
          4'd3:  cmdSet[7:0]  <= rdData;
          4'd4:  cmdSet[15:8] <= rdData;
          4'd5:  bTypW        <= rdData;
          4'd6:  bMaxW        <= rdData;
          4'd7:  bTypE        <= rdData;
          4'd8:  bMaxE        <= rdData;
          4'd9:  sizeExp      <= rdData;
          4'd10: rgnCount     <= (rdData > 8'(MAX_RGN)) ? 8'(MAX_RGN) : rdData;
          default: ;
        endcase
      end else begin
        case (stb.byteK)
          2'd0: tmp0 <= rdData;
          2'd1: tmp1 <= rdData;
          2'd2: tmp2 <= rdData;
          default: ;
        endcase
        if (commit) begin
          startTab[stb.rgn[RI_W-1:0]] <= runOff;
          blkTab[stb.rgn[RI_W-1:0]]   <= blkCnt;
          sizeTab[stb.rgn[RI_W-1:0]]  <= blkSize;
          runOff <= runOff + OFFS_W'(span);
        end
      end
    end
  end

  // base * 2^e, saturated to CNT_W bits
  function automatic logic [CNT_W-1:0] satPow(input logic [CNT_W-1:0] base,
                                              input logic [8:0] e);
    logic [2*CNT_W-1:0] wide;
    if (base == '0) begin
      satPow = '0;
    end else if (32'(e) >= CNT_W) begin
      satPow = '1;
    end else begin
      wide = {{CNT_W{1'b0}}, base} << e;
      satPow = (|wide[2*CNT_W-1:CNT_W]) ? '1 : wide[CNT_W-1:0];
    end
  endfunction

  assign wrTimeout = satPow(CNT_W'(CLK_PER_US), {1'b0, bTypW} + {1'b0, bMaxW});
  assign erTimeout = satPow(CNT_W'(CLK_PER_MS), {1'b0, bTypE} + {1'b0, bMaxE});
  assign devSize   = (32'(sizeExp) >= OFFS_W) ? '1 : (OFFS_W'(1) << sizeExp);

  // indexed read port
  always_comb begin
    rgnStart   = '0;
    rgnBlocks  = '0;
    rgnBlkSize = '0;
    if (rgnSel < rgnCount) begin
      rgnStart   = startTab[rgnSel[RI_W-1:0]];
      rgnBlocks  = blkTab[rgnSel[RI_W-1:0]];
      rgnBlkSize = sizeTab[rgnSel[RI_W-1:0]];
    end
  end

endmodule

// File: rtl/cfi_probe_top.sv
module cfi_probe_top
  import cfi_probe_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int MAX_RGN    = 8,
  parameter int CNT_W      = 40,
  parameter int OFFS_W     = 32,
  parameter int CLK_PER_US = 100,
  parameter int CLK_PER_MS = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              is16Bit,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrEn,
  output logic [7:0]        busWrData,
  output logic              busRdEn,
  input  logic [7:0]        busRdData,
  output logic              done,
  output logic              devValid,
  output logic [15:0]       cmdSet,
  output logic [OFFS_W-1:0] devSize,
  output logic [7:0]        numRegions,
  output logic [CNT_W-1:0]  wrTimeoutCyc,
  output logic [CNT_W-1:0]  erTimeoutCyc,
  input  logic [7:0]        rgnSel,
  output logic [OFFS_W-1:0] rgnStart,
  output logic [16:0]       rgnBlocks,
  output logic [23:0]       rgnBlkSize
);

  dpStrobe_t stb;
  logic      sigMiss;

  cfi_probe_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .is16Bit(is16Bit),
    .sigMiss(sigMiss), .cmdSet(cmdSet), .rgnCount(numRegions),
    .stb(stb), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .done(done), .devValid(devValid)
  );

  cfi_probe_dp #(
    .MAX_RGN(MAX_RGN), .CNT_W(CNT_W), .OFFS_W(OFFS_W),
    .CLK_PER_US(CLK_PER_US), .CLK_PER_MS(CLK_PER_MS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdData(busRdData),
    .sigMiss(sigMiss), .cmdSet(cmdSet), .rgnCount(numRegions),
    .wrTimeout(wrTimeoutCyc), .erTimeout(erTimeoutCyc), .devSize(devSize),
    .rgnSel(rgnSel), .rgnStart(rgnStart), .rgnBlocks(rgnBlocks),
    .rgnBlkSize(rgnBlkSize)
  );

endmodule

// File: rtl/cfi_probe_chk.sv
module cfi_probe_chk #(
  parameter int ADDR_W  = 24,
  parameter int MAX_RGN = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              is16Bit,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [7:0]        busWrData,
  input logic              busRdEn,
  input logic              done,
  input logic [7:0]        numRegions
);

  // R2: command accesses land on even byte addresses in 16-bit mode
  a_r2_even_addr: assert property (@(posedge clk) disable iff (!rstN)
    (is16Bit && (busWrEn || busRdEn)) |-> (busAddr[0] == 1'b0));

  // R2: one-cycle read requests
  a_r2_rd_single: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> !busRdEn);

  // R2: never read and write together
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(busRdEn && busWrEn));

  // R10: only reset, query and exit command codes are written
  a_r10_wr_codes: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |-> (busWrData == 8'hF0 || busWrData == 8'h98 || busWrData == 8'hFF));

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: bus idle while done
  a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(busWrEn || busRdEn));

  // R7: stored region count never exceeds the table depth
  a_r7_count_clip: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (32'(numRegions) <= MAX_RGN));

endmodule

bind cfi_probe_top cfi_probe_chk #(.ADDR_W(ADDR_W), .MAX_RGN(MAX_RGN)) u_chk (
  .clk(clk), .rstN(rstN), .is16Bit(is16Bit), .busAddr(busAddr),
  .busWrEn(busWrEn), .busWrData(busWrData), .busRdEn(busRdEn),
  .done(done), .numRegions(numRegions)
);

// File: tb/sim_cfi_probe_top.sv
module sim_cfi_probe_top;

  localparam int ADDR_W = 24;
  localparam int MAXR   = 8;
  localparam int CNT_W  = 40;
  localparam int OFFS_W = 32;
  localparam longint US = 100;
  localparam longint MS = 100000;

  logic clk = 1'b0;
  logic rstN, start, is16Bit;
  logic [ADDR_W-1:0] busAddr;
  logic busWrEn, busRdEn, done, devValid;
  logic [7:0] busWrData, busRdData, numRegions, rgnSel;
  logic [15:0] cmdSet;
  logic [OFFS_W-1:0] devSize, rgnStart;
  logic [CNT_W-1:0] wrTimeoutCyc, erTimeoutCyc;
  logic [16:0] rgnBlocks;
  logic [23:0] rgnBlkSize;

  always #5 clk = ~clk;

  cfi_probe_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .is16Bit(is16Bit),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(busRdData), .done(done), .devValid(devValid),
    .cmdSet(cmdSet), .devSize(devSize), .numRegions(numRegions),
    .wrTimeoutCyc(wrTimeoutCyc), .erTimeoutCyc(erTimeoutCyc),
    .rgnSel(rgnSel), .rgnStart(rgnStart), .rgnBlocks(rgnBlocks),
    .rgnBlkSize(rgnBlkSize)
  );

  // flash model: query space indexed by command offset, one-cycle read latency
  logic [7:0] qmem [0:127];
  always @(posedge clk) begin
    if (busRdEn) busRdData <= qmem[7'(is16Bit ? (busAddr >> 1) : busAddr)];
  end

  int nChecks = 0;
  int nFails  = 0;
  int doneCnt = 0;
  logic [31:0] expWrQ [$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for bus writes (R1, R2, R10)
  always @(negedge clk) begin
    if (rstN === 1'b1 && done === 1'b1) doneCnt++;
    if (rstN === 1'b1 && busWrEn === 1'b1) begin
      if (expWrQ.size() == 0) begin
        chk(1'b0, "R10 unexpected write", longint'({busAddr, busWrData}), 0);
      end else begin
        logic [31:0] e;
        e = expWrQ.pop_front();
        chk({busAddr, busWrData} == e, "R1/R2 write addr/data",
            longint'({busAddr, busWrData}), longint'(e));
      end
    end
  end

  task automatic expectWrite(input bit m16, input int off, input logic [7:0] d);
    logic [ADDR_W-1:0] a;
    a = m16 ? ADDR_W'(off << 1) : ADDR_W'(off);
    expWrQ.push_back({a, d});
  endtask

  // test image description
  logic [7:0]  iCmdLo, iCmdHi, iTw, iMw, iTe, iMe, iSz, iNr;
  logic [15:0] iBlkW [0:15];
  logic [15:0] iSzW  [0:15];
  bit          iBadSig;

  task automatic loadImage();
    for (int i = 0; i < 128; i++) qmem[i] = 8'h00;
    qmem[16] = 8'h51; qmem[17] = iBadSig ? 8'h58 : 8'h52; qmem[18] = 8'h59;
    qmem[19] = iCmdLo; qmem[20] = iCmdHi;
    qmem[31] = iTw; qmem[35] = iMw; qmem[33] = iTe; qmem[37] = iMe;
    qmem[39] = iSz; qmem[44] = iNr;
    for (int r = 0; r < 16 && r < int'(iNr); r++) begin
      qmem[45 + 4*r]     = iBlkW[r][7:0];
      qmem[45 + 4*r + 1] = iBlkW[r][15:8];
      qmem[45 + 4*r + 2] = iSzW[r][7:0];
      qmem[45 + 4*r + 3] = iSzW[r][15:8];
    end
  endtask

  function automatic longint satTo(input longint base, input int e);
    logic [127:0] v;
    if (e >= CNT_W) return (longint'(1) << CNT_W) - 1;
    v = 128'(base) << e;
    if (v > 128'hFF_FFFF_FFFF) return (longint'(1) << CNT_W) - 1;
    return longint'(v[63:0]);
  endfunction

  task automatic waitDone(output bit seen);
    seen = 1'b0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (done === 1'b1) begin seen = 1'b1; break; end
    end
    if (!seen) chk(1'b0, "R11 watchdog: no done", 0, 1);
  endtask

  task automatic runProbe(input bit m16, input bit midStart, input string name);
    bit seen;
    int cmd, nStored;
    longint acc;
    loadImage();
    cmd = int'({iCmdHi, iCmdLo});
    expWrQ.delete();
    expectWrite(m16, 0, 8'hF0);
    expectWrite(m16, 'h55, 8'h98);
    if (!iBadSig) begin
      if (cmd == 2) begin expectWrite(m16, 0, 8'hF0); expectWrite(m16, 0, 8'hFF); end
      else if (cmd == 1 || cmd == 3) expectWrite(m16, 0, 8'hFF);
    end
    @(negedge clk);
    is16Bit = m16;
    doneCnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (midStart) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitDone(seen);
    if (!seen) return;
    $display("run %s", name);
    chk(devValid == !iBadSig, "R3 devValid", longint'(devValid), longint'(!iBadSig));
    if (!iBadSig) begin
      chk(cmdSet == 16'(cmd), "R4 cmdSet", longint'(cmdSet), longint'(cmd));
      chk(wrTimeoutCyc == CNT_W'(satTo(US, int'(iTw) + int'(iMw))), "R5 write timeout",
          longint'(wrTimeoutCyc), satTo(US, int'(iTw) + int'(iMw)));
      chk(erTimeoutCyc == CNT_W'(satTo(MS, int'(iTe) + int'(iMe))), "R5 erase timeout",
          longint'(erTimeoutCyc), satTo(MS, int'(iTe) + int'(iMe)));
      begin
        longint es;
        es = (int'(iSz) >= OFFS_W) ? 64'hFFFF_FFFF : (longint'(1) << iSz);
        chk(longint'(devSize) == es, "R6 devSize", longint'(devSize), es);
      end
      nStored = (int'(iNr) > MAXR) ? MAXR : int'(iNr);
      chk(int'(numRegions) == nStored, "R7 numRegions", longint'(numRegions), longint'(nStored));
      acc = 0;
      for (int r = 0; r <= MAXR; r++) begin
        longint eb, es2, eo;
        if (r < nStored) begin
          eb  = longint'(iBlkW[r]) + 1;
          es2 = (iSzW[r] == 16'd0) ? 128 : longint'(iSzW[r]) * 256;
          eo  = acc;
          acc = (acc + eb * es2) & 64'hFFFF_FFFF;
        end else begin
          eb = 0; es2 = 0; eo = 0;
        end
        rgnSel = 8'(r);
        #1;
        chk(longint'(rgnBlocks) == eb, "R8 block count", longint'(rgnBlocks), eb);
        chk(longint'(rgnBlkSize) == es2, "R8 block size", longint'(rgnBlkSize), es2);
        chk(longint'(rgnStart) == eo, "R9 start offset", longint'(rgnStart), eo);
      end
    end
    repeat (3) @(negedge clk);
    chk(expWrQ.size() == 0, "R10 missing exit writes", longint'(expWrQ.size()), 0);
    chk(doneCnt == 1, "R11 single done pulse", longint'(doneCnt), 1);
    chk(done == 1'b0 && busRdEn == 1'b0 && busWrEn == 1'b0, "R3 bus quiet after done",
        longint'({done, busRdEn, busWrEn}), 0);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; is16Bit = 1'b0; rgnSel = '0;
    for (int i = 0; i < 128; i++) qmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && devValid == 1'b0 && busWrEn == 1'b0 && busRdEn == 1'b0,
        "R11 reset state", longint'({done, devValid, busWrEn, busRdEn}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // A: 16-bit, command set 2, three regions including size code 0
    iBadSig = 0; iCmdLo = 8'h02; iCmdHi = 8'h00;
    iTw = 4; iMw = 3; iTe = 9; iMe = 4; iSz = 8'h18; iNr = 3;
    iBlkW[0] = 16'h0007; iSzW[0] = 16'h0020;
    iBlkW[1] = 16'h003E; iSzW[1] = 16'h0100;
    iBlkW[2] = 16'h0001; iSzW[2] = 16'h0000;
    runProbe(1'b1, 1'b0, "A");

    // B: 8-bit, command set 1, ten regions clipped, saturating timeouts and size
    iCmdLo = 8'h01; iTw = 20; iMw = 20; iTe = 30; iMe = 10; iSz = 40; iNr = 10;
    for (int r = 0; r < 10; r++) begin iBlkW[r] = 16'(r); iSzW[r] = 16'(r + 1); end
    runProbe(1'b0, 1'b0, "B");

    // C: bad signature -> no exit writes, devValid low (R3)
    iBadSig = 1; iCmdLo = 8'h02; iNr = 2;
    runProbe(1'b1, 1'b0, "C");

    // D: 8-bit, command set 3, no regions, start repeated mid-run (R11)
    iBadSig = 0; iCmdLo = 8'h03; iTw = 0; iMw = 0; iTe = 0; iMe = 0; iSz = 0; iNr = 0;
    runProbe(1'b0, 1'b1, "D");

    // E: 16-bit, unknown command set 0x0107 with high byte set, max descriptor
    iCmdLo = 8'h07; iCmdHi = 8'h01; iTw = 1; iMw = 2; iTe = 3; iMe = 1; iSz = 8'h1F; iNr = 1;
    iBlkW[0] = 16'hFFFF; iSzW[0] = 16'hFFFF;
    runProbe(1'b1, 1'b0, "E");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule